// File: doc/BRIEF.md
# PCM B-Channel Serial Port with Host Override

This block is the serial voice port of a codec. It moves one 8-bit companded sample per frame in each direction. A frame sync pulse starts each frame, and a bit clock counts the bit positions after it. The port drives one byte onto the transmit line during the selected B-channel time slot, most significant bit first. In the same slot it assembles one byte from the receive line and hands that byte to the decoder with a single-cycle valid strobe.

A small control word sets up the port. It enables the port, picks the B1 or B2 slot, steers either direction to a host-written byte instead of live data, and sets a latch output pin. When transmit override is on, the slot carries a host byte in place of the encoder byte. When receive override is on, the decoder gets a host byte in place of the line sample, and the sampled line byte can still be read back. A linear-mode input turns both overrides off. The block runs on one system clock. It finds the edges of the bit clock by sampling it, and the bit clock is taken to be slower than the system clock and in phase with it.

Top module: `pcm_bchan_port`

## Requirements
- R1: After reset the port is disabled (control bit 0 = 0). While it is disabled, `dx_oe` stays 0 and `dec_valid` never pulses, whatever arrives on `dr`.
- R2: Control bit 1 selects the slot: 0 selects B1, which is bit positions 0 to 7 after frame sync, and 1 selects B2, which is positions 8 to 15. After reset B1 is selected.
- R3: While the port is enabled, `dx_oe` is 1 for exactly the 8 bit periods of the selected slot and 0 at all other times. `dx_oe` and `dx` change only in the system cycle that follows a sampled rising edge of `bclk`. The byte goes out most significant bit first.
- R4: `dr` is sampled at falling edges of `bclk` within the selected slot, most significant bit first. After the eighth sample, `dec_valid` is 1 for exactly one cycle, once per frame.
- R5: When control bit 2 (transmit override) is 1, the slot carries the last byte written through `txo_wdata`, and `enc_byte` is ignored. The transmit override byte cannot be read back.
- R6: When control bit 3 (receive override) is 1, `dec_byte` at each strobe carries the last byte written through `rxo_wdata`, and `dr` has no effect on it.
- R7: `rxo_rdata` holds the most recent byte sampled from `dr` in the selected slot. It is updated on every frame, including when receive override is on.
- R8: While `linear_mode` is 1, both override bits act as 0.
- R9: `latch_out` is the inverse of control bit 4. Writing 1 drives the pin low. After reset the pin is high.
- R10: The source byte for a slot is taken at the slot's first rising bit-clock edge. If `enc_byte` changes later in the slot, the byte already being sent does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bclk | input | 1 | PCM bit clock, sampled by `clk` |
| fsync | input | 1 | Frame sync, sampled at a rising `bclk` edge; marks bit position 0 |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for `dx`; 0 means high impedance |
| enc_byte | input | BYTE_W | Byte from the encoder |
| dec_byte | output | BYTE_W | Byte to the decoder |
| dec_valid | output | 1 | One-cycle strobe that qualifies `dec_byte` |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 5 | Control word: [0] enable, [1] B2 select, [2] transmit override, [3] receive override, [4] latch control |
| txo_we | input | 1 | Write strobe for the transmit override byte |
| txo_wdata | input | BYTE_W | Transmit override byte |
| rxo_we | input | 1 | Write strobe for the receive override byte |
| rxo_wdata | input | BYTE_W | Receive override byte |
| rxo_rdata | output | BYTE_W | Last byte sampled from `dr` |
| linear_mode | input | 1 | Linear mode; turns both overrides off while 1 |
| latch_out | output | 1 | Latch output pin |

## Verification
The bench builds the port with BYTE_W = 8 and CNT_W = 5. With these values a 32-bit frame spans the whole counter range, so the counter reaches its saturation value on the last bit of every frame, and both slots and the gap after them all occur in each frame. Each bit period is eight system cycles. This puts the edge detection, the one-cycle strobe and a change of the encoder byte in the middle of a slot all within a few hundred cycles per scenario.

// File: rtl/pcm_bchan_pkg.sv
package pcm_bchan_pkg;

  // Control word layout, MSB first: latch, rx override, tx override, slot, enable
  typedef struct packed {
    logic latch_ctl;
    logic rx_ovr;
    logic tx_ovr;
    logic slot_b2;
    logic en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic slot_b2,
  output logic bit_rise,
  output logic tx_act,
  output logic tx_first,
  output logic rx_act,
  output logic rx_last
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   SPAN    = (CNT_W+1)'(BYTE_W);

  logic             bclk_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, idx_now;
  logic [CNT_W-1:0] base;
  logic             bit_fall;

  function automatic logic in_slot(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] b);
    return ({1'b0, v} >= {1'b0, b}) && ({1'b0, v} < ({1'b0, b} + SPAN));
  endfunction

  assign bit_rise = bclk & ~bclk_q;
  assign bit_fall = ~bclk & bclk_q;
  assign base     = slot_b2 ? CNT_W'(BYTE_W) : '0;

  always_comb begin
    if (fsync)               idx_now = '0;
    else if (cnt_q == CNT_MAX) idx_now = CNT_MAX;
    else                     idx_now = cnt_q + 1'b1;
    cnt_d = bit_rise ? idx_now : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      cnt_q  <= CNT_MAX;
    end else begin
      bclk_q <= bclk;
      if (bit_rise) cnt_q <= cnt_d;
    end
  end

  assign tx_act   = bit_rise & in_slot(idx_now, base);
  assign tx_first = bit_rise & (idx_now == base);
  assign rx_act   = bit_fall & in_slot(cnt_q, base);
  assign rx_last  = rx_act & ({1'b0, cnt_q} == ({1'b0, base} + SPAN - 1'b1));

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_rise,
  input  logic              bit_act,
  input  logic              bit_first,
  input  logic [BYTE_W-1:0] src,
  output logic              dx,
  output logic              dx_oe
);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              dx_q, dx_d, oe_q, oe_d;

  always_comb begin
    sh_d = sh_q;
    dx_d = dx_q;
    oe_d = oe_q;
    if (!en) begin
      oe_d = 1'b0;
    end else if (bit_rise) begin
      oe_d = bit_act;
      if (bit_act && bit_first) begin
        dx_d = src[BYTE_W-1];
        sh_d = {src[BYTE_W-2:0], 1'b0};
      end else if (bit_act) begin
        dx_d = sh_q[BYTE_W-1];
        sh_d = {sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      dx_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      dx_q <= dx_d;
      oe_q <= oe_d;
    end
  end

  assign dx    = dx_q;
  assign dx_oe = oe_q;

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_act,
  input  logic              bit_last,
  input  logic              dr,
  input  logic              ovr,
  input  logic [BYTE_W-1:0] ovr_byte,
  output logic [BYTE_W-1:0] cap_byte,
  output logic [BYTE_W-1:0] dec_byte,
  output logic              dec_valid
);

  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [BYTE_W-1:0] cap_q, cap_d, dec_q, dec_d;
  logic              val_q, val_d;
  logic [BYTE_W-1:0] assembled;

  assign assembled = {sh_q, dr};

  always_comb begin
    sh_d  = sh_q;
    cap_d = cap_q;
    dec_d = dec_q;
    val_d = 1'b0;
    if (en && bit_act) begin
      sh_d = assembled[BYTE_W-2:0];
      if (bit_last) begin
        cap_d = assembled;
        dec_d = ovr ? ovr_byte : assembled;
        val_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cap_q <= '0;
      dec_q <= '0;
      val_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cap_q <= cap_d;
      dec_q <= dec_d;
      val_q <= val_d;
    end
  end

  assign cap_byte  = cap_q;
  assign dec_byte  = dec_q;
  assign dec_valid = val_q;

endmodule

// File: rtl/pcm_bchan_port.sv
module pcm_bchan_port
  import pcm_bchan_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              dr,
  output logic              dx,
  output logic              dx_oe,
  input  logic [BYTE_W-1:0] enc_byte,
  output logic [BYTE_W-1:0] dec_byte,
  output logic              dec_valid,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              txo_we,
  input  logic [BYTE_W-1:0] txo_wdata,
  input  logic              rxo_we,
  input  logic [BYTE_W-1:0] rxo_wdata,
  output logic [BYTE_W-1:0] rxo_rdata,
  input  logic              linear_mode,
  output logic              latch_out
);

  logic              srst_n;
  ctl_t              ctl_q;
  logic [BYTE_W-1:0] txo_q, rxo_q;
  logic              tx_ovr_eff, rx_ovr_eff, port_en;
  logic [BYTE_W-1:0] tx_src;
  logic              bit_rise, tx_act, tx_first, rx_act, rx_last;

  pcm_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (srst_n)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= '0;
      txo_q <= '0;
      rxo_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
      if (txo_we) txo_q <= txo_wdata;
      if (rxo_we) rxo_q <= rxo_wdata;
    end
  end

  assign port_en    = ctl_q.en;
  assign tx_ovr_eff = ctl_q.tx_ovr & ~linear_mode;
  assign rx_ovr_eff = ctl_q.rx_ovr & ~linear_mode;
  assign tx_src     = tx_ovr_eff ? txo_q : enc_byte;
  assign latch_out  = ~ctl_q.latch_ctl;

  pcm_slot_timer #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .bclk     (bclk),
    .fsync    (fsync),
    .slot_b2  (ctl_q.slot_b2),
    .bit_rise (bit_rise),
    .tx_act   (tx_act),
    .tx_first (tx_first),
    .rx_act   (rx_act),
    .rx_last  (rx_last)
  );

  pcm_tx_shifter #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (srst_n),
    .en        (port_en),
    .bit_rise  (bit_rise),
    .bit_act   (tx_act),
    .bit_first (tx_first),
    .src       (tx_src),
    .dx        (dx),
    .dx_oe     (dx_oe)
  );

  pcm_rx_shifter #(.BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (srst_n),
    .en        (port_en),
    .bit_act   (rx_act),
    .bit_last  (rx_last),
    .dr        (dr),
    .ovr       (rx_ovr_eff),
    .ovr_byte  (rxo_q),
    .cap_byte  (rxo_rdata),
    .dec_byte  (dec_byte),
    .dec_valid (dec_valid)
  );

endmodule

// File: rtl/pcm_bchan_chk.sv
module pcm_bchan_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bclk,
  input logic              dx_oe,
  input logic              dec_valid,
  input logic [BYTE_W-1:0] dec_byte,
  input logic [BYTE_W-1:0] rxo_rdata,
  input logic              latch_out,
  input logic              ctl_we,
  input logic [4:0]        ctl_wdata,
  input logic              port_en,
  input logic              rx_ovr_eff,
  input logic [BYTE_W-1:0] rxo_q
);

  // R1
  oe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dx_oe |-> port_en);

  // R1
  strobe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(port_en));

  // R3
  oe_starts_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> ($past(bclk) && !$past(bclk, 2)));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R6
  rx_override_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(rx_ovr_eff)) |-> (dec_byte == $past(rxo_q)));

  // R7
  live_byte_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !$past(rx_ovr_eff)) |-> (dec_byte == rxo_rdata));

  // R9
  latch_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_we) |-> (latch_out == !$past(ctl_wdata[4])));

endmodule

bind pcm_bchan_port pcm_bchan_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .bclk       (bclk),
  .dx_oe      (dx_oe),
  .dec_valid  (dec_valid),
  .dec_byte   (dec_byte),
  .rxo_rdata  (rxo_rdata),
  .latch_out  (latch_out),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .port_en    (port_en),
  .rx_ovr_eff (rx_ovr_eff),
  .rxo_q      (rxo_q)
);

// File: tb/pcm_bchan_port_bench.sv
module pcm_bchan_port_bench;

  localparam int BW    = 8;
  localparam int CW    = 5;
  localparam int CMAX  = 31;
  localparam int FRAME = 32;
  localparam int HALF  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bclk = 1'b0, fsync = 1'b0, dr = 1'b0;
  logic          dx, dx_oe, dec_valid, latch_out;
  logic [BW-1:0] enc_byte = '0, dec_byte, rxo_rdata;
  logic          ctl_we = 1'b0, txo_we = 1'b0, rxo_we = 1'b0, linear_mode = 1'b0;
  logic [4:0]    ctl_wdata = '0;
  logic [BW-1:0] txo_wdata = '0, rxo_wdata = '0;

  always #5 clk = ~clk;

  pcm_bchan_port #(.BYTE_W(BW), .CNT_W(CW)) u_pcm_bchan_port (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr),
    .dx(dx), .dx_oe(dx_oe), .enc_byte(enc_byte), .dec_byte(dec_byte),
    .dec_valid(dec_valid), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .txo_we(txo_we), .txo_wdata(txo_wdata), .rxo_we(rxo_we),
    .rxo_wdata(rxo_wdata), .rxo_rdata(rxo_rdata),
    .linear_mode(linear_mode), .latch_out(latch_out)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0, live = 0, go = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model, updated at every rising clock edge
  int  m_prev, m_cnt, m_dec, m_rb, m_txo, m_rxo;
  bit  m_dx, m_oe, m_val;
  bit [4:0] m_ctl;
  bit  txq[$];
  bit  rxq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_cnt = CMAX; m_dec = 0; m_rb = 0; m_txo = 0; m_rxo = 0;
      m_dx = 0; m_oe = 0; m_val = 0; m_ctl = '0;
      txq.delete(); rxq.delete();
    end else begin
      int base, src, b;
      bit rise, fall, en, lin;
      rise = bclk && (m_prev == 0);
      fall = !bclk && (m_prev == 1);
      m_prev = bclk;
      en   = m_ctl[0];
      lin  = linear_mode;
      base = m_ctl[1] ? BW : 0;
      m_val = 0;
      if (!en) m_oe = 0;
      else if (rise) begin
        m_cnt = fsync ? 0 : ((m_cnt >= CMAX) ? CMAX : m_cnt + 1);
        if (m_cnt >= base && m_cnt < base + BW) begin
          if (m_cnt == base) begin
            src = (m_ctl[2] && !lin) ? m_txo : int'(enc_byte);
            txq.delete();
            for (int i = BW - 1; i >= 0; i--) txq.push_back(src[i]);
          end
          m_oe = 1;
          m_dx = (txq.size() > 0) ? txq.pop_front() : 1'b0;
        end else m_oe = 0;
      end else if (fall && m_cnt >= base && m_cnt < base + BW) begin
        rxq.push_back(dr);
        if (rxq.size() > BW) void'(rxq.pop_front());
        if (m_cnt == base + BW - 1) begin
          b = 0;
          foreach (rxq[i]) b = (b << 1) | int'(rxq[i]);
          m_rb  = b;
          m_dec = (m_ctl[3] && !lin) ? m_rxo : b;
          m_val = 1;
        end
      end
      if (rise && !en) m_cnt = fsync ? 0 : ((m_cnt >= CMAX) ? CMAX : m_cnt + 1);
      if (ctl_we) m_ctl = ctl_wdata;
      if (txo_we) m_txo = int'(txo_wdata);
      if (rxo_we) m_rxo = int'(rxo_wdata);
    end
  end

  // Per-clock comparison and phase statistics
  int v_cnt = 0, oe_cnt = 0, last_dec = 0;
  always @(negedge clk) begin
    if (live) begin
      chk("R1 R3", "dx_oe", int'(dx_oe), int'(m_oe));
      if (m_oe) chk("R3 R5 R10", "dx", int'(dx), int'(m_dx));
      chk("R4", "dec_valid", int'(dec_valid), int'(m_val));
      if (m_val) chk("R6 R8", "dec_byte", int'(dec_byte), m_dec);
      chk("R7", "rxo_rdata", int'(rxo_rdata), m_rb);
      chk("R9", "latch_out", int'(latch_out), int'(!m_ctl[4]));
      if (dec_valid) begin v_cnt++; last_dec = int'(dec_byte); end
      if (dx_oe) oe_cnt++;
    end
  end

  // Bit clock, frame sync and receive data
  initial begin
    bit [7:0] pat;
    pat = 8'h96;
    wait (go);
    forever begin
      for (int b = 0; b < FRAME; b++) begin
        @(negedge clk);
        if (b == 0) pat = pat * 8'd5 + 8'd3;
        bclk = 1'b1; fsync = (b == 0); dr = pat[7 - (b % 8)];
        repeat (HALF) @(negedge clk);
        bclk = 1'b0;
        repeat (HALF - 1) @(negedge clk);
      end
    end
  end

  task automatic gap();
    do @(negedge clk); while (m_cnt < 18 || m_cnt > 26);
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    gap(); ctl_we = 1'b1; ctl_wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic run_frames(input int n);
    v_cnt = 0; oe_cnt = 0;
    repeat (n * FRAME * 2 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "reset dx_oe", int'(dx_oe), 0);
    chk("R9", "reset latch_out", int'(latch_out), 1);
    chk("R4", "reset dec_valid", int'(dec_valid), 0);
    chk("R7", "reset rxo_rdata", int'(rxo_rdata), 0);
    live = 1; go = 1;

    // R2: enable only, slot stays at reset B1; R10 field layout
    gap(); enc_byte = 8'hA5;
    wr_ctl(5'b00001);
    run_frames(1);
    chk("R4", "strobes per frame B1", v_cnt, 1);
    chk("R2", "oe cycles per frame B1", oe_cnt, BW * 2 * HALF);
    // R10: change encoder byte in the middle of the B1 slot
    do @(negedge clk); while (m_cnt != 3);
    enc_byte = 8'h5A;
    run_frames(2);

    // R2: B2 slot
    wr_ctl(5'b00011);
    run_frames(3);
    chk("R2", "strobes B2", v_cnt, 3);

    // R5: transmit override
    gap(); txo_we = 1'b1; txo_wdata = 8'h3C; @(negedge clk); txo_we = 1'b0;
    wr_ctl(5'b00101);
    run_frames(2);

    // R6: receive override
    gap(); rxo_we = 1'b1; rxo_wdata = 8'h81; @(negedge clk); rxo_we = 1'b0;
    wr_ctl(5'b01001);
    run_frames(2);
    chk("R6", "override byte to decoder", last_dec, 8'h81);
    chk("R7", "readback differs from override", int'(rxo_rdata != 8'h81), 1);

    // R8: linear mode cancels both overrides
    linear_mode = 1'b1;
    wr_ctl(5'b01111);
    run_frames(2);
    chk("R8", "decoder gets live byte", last_dec, int'(rxo_rdata));
    linear_mode = 1'b0;

    // R1 and R9: disabled port with latch bit set
    wr_ctl(5'b10000);
    repeat (2) @(negedge clk);
    chk("R9", "latch written 1", int'(latch_out), 0);
    run_frames(2);
    chk("R1", "no strobes while disabled", v_cnt, 0);
    chk("R1", "no drive while disabled", oe_cnt, 0);
    wr_ctl(5'b00000);
    repeat (2) @(negedge clk);
    chk("R9", "latch written 0", int'(latch_out), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule